// File: doc/BRIEF.md
# Memory-Mode Prefix Decoder

This block sits beside the opcode fetch unit of an 8-bit CPU core that can run either with 16-bit registers inside a 64 KiB window or with full 24-bit registers and addresses. Every byte fetched as an opcode is shown to the block with a one-cycle strobe. Four otherwise useless register-to-self copy opcodes act as memory-mode prefixes. Each one sets two one-shot override flags for the instruction that follows. The first flag picks short (16-bit) or long (24-bit) data and addressing. The second picks 2-byte or 3-byte immediates. When no such prefix is present, both flags take the value of the persistent mode bit, which the control-transfer logic may rewrite.

The block also follows the classic escape prefixes (CBh, DDh, EDh, FDh), so that it can tell the interrupt controller when an interrupt must not be taken between two bytes of one instruction. It checks that a memory-mode prefix comes before any escape prefix. A misplaced memory-mode code is reported as an ordering error and is decoded as a plain opcode. Finally, it forms the effective data address from the register value and the upper address base. The address is the register as it is in long mode, and the base joined to the low 16 register bits in short mode.

Top module: `mmode_prefix_dec`

## Requirements
- R1: After reset the persistent mode bit `adl` is 0, and `prefix_active`, `long_data`, `long_imm`, `int_block` and `order_error` are all 0.
- R2: A memory-mode code accepted as a prefix sets `prefix_active`=1 after its strobe edge. Its two low bits select the widths: bit 0 set means long data and bit 1 set means long immediate. The codes are 40h (both short), 49h (long data, short immediate), 52h (short data, long immediate) and 5Bh (both long).
- R3: For an instruction with no memory-mode prefix, both `long_data` and `long_imm` equal `adl` as sampled at the instruction's first fetch, and `prefix_active` is 0.
- R4: The override flags from a prefix hold through every later opcode fetch of the same instruction. They are replaced at the first fetch of the next instruction. A prefix never changes `adl`.
- R5: `int_block` is 1 after the strobe of any byte accepted as a prefix (a memory-mode code or an escape prefix). It is 0 after the strobe of the byte that ends the prefix chain.
- R6: After DDh or FDh, any of CBh/DDh/EDh/FDh is taken as a further prefix. After CBh or EDh, the next opcode byte ends the instruction whatever its value.
- R7: A memory-mode code fetched after an escape prefix of the same instruction is not a prefix. It sets `order_error`=1 and `int_block`=0 and leaves the flags unchanged. `order_error` returns to 0 at the next strobe.
- R8: `ea` equals `hl` when `long_data`=1. When `long_data`=0, `ea` is {`mbase`, `hl`[15:0]}.
- R9: A write of the mode bit (`adl_we`) shows on `adl` one edge later. It affects the flags only from the next instruction's first fetch onward, not in the instruction already under way.
- R10: `prefix_active`, `long_data`, `long_imm`, `int_block` and `order_error` change only on an edge where `fetch_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stb | input | 1 | Opcode byte on `opcode` is fetched this cycle |
| opcode | input | 8 | Fetched opcode byte |
| adl_we | input | 1 | Load the persistent mode bit |
| adl_d | input | 1 | New mode bit value (1 = 24-bit mode) |
| mbase | input | ADDR_W-LOW_W (8) | Upper address base for short addressing |
| hl | input | ADDR_W (24) | Register value used as data address |
| adl | output | 1 | Persistent mode bit |
| prefix_active | output | 1 | A memory-mode prefix governs the current instruction |
| long_data | output | 1 | 24-bit data and addressing selected |
| long_imm | output | 1 | 3-byte immediates selected |
| int_block | output | 1 | Interrupts must not be accepted before the next fetch |
| order_error | output | 1 | Memory-mode code seen after an escape prefix |
| ea | output | ADDR_W (24) | Effective data address |

## Verification
The hardest situation to reach is a memory-mode code that lands after an escape prefix in the same instruction. It needs a closed instruction boundary, then one or two escape bytes, then the code, and the expected outcome depends on whether an earlier memory-mode prefix already set the flags. The stimulus sweeps every escape byte against every memory-mode code under both mode-bit values. It adds one case where a valid prefix comes first. The bench also writes the mode bit partway through an instruction to show that the new value waits for the next instruction boundary.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

  localparam int OP_W = 8;

  typedef enum logic [1:0] {
    BK_PLAIN    = 2'd0,
    BK_MODE     = 2'd1,
    BK_ESC_OPEN = 2'd2,
    BK_ESC_LAST = 2'd3
  } byte_kind_e;

  typedef struct packed {
    logic long_imm;
    logic long_data;
  } width_sel_t;

  // The four mode codes are the self-copies of the first four registers:
  // 01_rrr_rrr with rrr in 0..3, so bits [5:3] mirror bits [2:0].
  function automatic logic is_mode_code(input logic [OP_W-1:0] b);
    return (b[7:6] == 2'b01) && (b[5] == 1'b0) && (b[5:3] == b[2:0]);
  endfunction

  function automatic width_sel_t code_widths(input logic [OP_W-1:0] b);
    width_sel_t s;
    s.long_data = b[0];
    s.long_imm  = b[1];
    return s;
  endfunction

  function automatic byte_kind_e classify(input logic [OP_W-1:0] b);
    byte_kind_e k;
    if (is_mode_code(b))                       k = BK_MODE;
    else if (b == 8'hDD || b == 8'hFD)         k = BK_ESC_OPEN;
    else if (b == 8'hCB || b == 8'hED)         k = BK_ESC_LAST;
    else                                       k = BK_PLAIN;
    return k;
  endfunction

endpackage

// File: rtl/mmp_byte_class.sv
module mmp_byte_class
  import mmp_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output byte_kind_e      kind,
  output width_sel_t      sel
);
  always_comb begin
    kind = classify(op);
    sel  = code_widths(op);
  end
endmodule

// File: rtl/mmp_mode_reg.sv
module mmp_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/mmp_seq.sv
module mmp_seq
  import mmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  byte_kind_e kind,
  input  width_sel_t sel,
  input  logic       mode_bit,
  output logic       pa_q,
  output logic       ld_q,
  output logic       li_q,
  output logic       ib_q,
  output logic       oe_q,
  output logic       ev_boundary,
  output logic       ev_mode_pref,
  output logic       ev_esc,
  output logic       ev_final,
  output logic       ev_misplaced
);
  logic done_q, esc_q, closed_q;
  logic b_esc, b_closed, b_pa, b_ld, b_li;

  always_comb begin
    ev_boundary  = done_q;
    b_esc        = done_q ? 1'b0     : esc_q;
    b_closed     = done_q ? 1'b0     : closed_q;
    b_pa         = done_q ? 1'b0     : pa_q;
    b_ld         = done_q ? mode_bit : ld_q;
    b_li         = done_q ? mode_bit : li_q;
    ev_mode_pref = (kind == BK_MODE) && !b_esc;
    ev_misplaced = (kind == BK_MODE) && b_esc;
    ev_esc       = ((kind == BK_ESC_OPEN) || (kind == BK_ESC_LAST)) && !b_closed;
    ev_final     = !ev_mode_pref && !ev_esc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b1;
      esc_q    <= 1'b0;
      closed_q <= 1'b0;
      pa_q     <= 1'b0;
      ld_q     <= 1'b0;
      li_q     <= 1'b0;
      ib_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stb) begin
      done_q   <= ev_final;
      esc_q    <= b_esc | ev_esc;
      closed_q <= b_closed | (ev_esc && (kind == BK_ESC_LAST));
      pa_q     <= b_pa | ev_mode_pref;
      ld_q     <= ev_mode_pref ? sel.long_data : b_ld;
      li_q     <= ev_mode_pref ? sel.long_imm  : b_li;
      ib_q     <= !ev_final;
      oe_q     <= ev_misplaced;
    end
  end
endmodule

// File: rtl/mmp_addr_gen.sv
module mmp_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input  logic                    long_data,
  input  logic [ADDR_W-LOW_W-1:0] base,
  input  logic [ADDR_W-1:0]       rv,
  output logic [ADDR_W-1:0]       ea
);
  localparam int HI_W = ADDR_W - LOW_W;

  function automatic logic [ADDR_W-1:0] form_ea(input logic lng,
                                                input logic [HI_W-1:0] b,
                                                input logic [ADDR_W-1:0] r);
    return lng ? r : {b, r[LOW_W-1:0]};
  endfunction

  always_comb ea = form_ea(long_data, base, rv);
endmodule

// File: rtl/mmode_prefix_dec.sv
module mmode_prefix_dec
  import mmp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_stb,
  input  logic [7:0]              opcode,
  input  logic                    adl_we,
  input  logic                    adl_d,
  input  logic [ADDR_W-LOW_W-1:0] mbase,
  input  logic [ADDR_W-1:0]       hl,
  output logic                    adl,
  output logic                    prefix_active,
  output logic                    long_data,
  output logic                    long_imm,
  output logic                    int_block,
  output logic                    order_error,
  output logic [ADDR_W-1:0]       ea
);
  byte_kind_e kind;
  width_sel_t sel;
  logic ev_boundary, ev_mode_pref, ev_esc, ev_final, ev_misplaced;

  mmp_byte_class u_cls (.op(opcode), .kind(kind), .sel(sel));

  mmp_mode_reg u_mode (.clk(clk), .rst_n(rst_n), .we(adl_we), .d(adl_d), .q(adl));

  mmp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stb(fetch_stb), .kind(kind), .sel(sel),
    .mode_bit(adl),
    .pa_q(prefix_active), .ld_q(long_data), .li_q(long_imm),
    .ib_q(int_block), .oe_q(order_error),
    .ev_boundary(ev_boundary), .ev_mode_pref(ev_mode_pref), .ev_esc(ev_esc),
    .ev_final(ev_final), .ev_misplaced(ev_misplaced)
  );

  mmp_addr_gen #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_ea (
    .long_data(long_data), .base(mbase), .rv(hl), .ea(ea)
  );
endmodule

// File: rtl/mmp_checker.sv
module mmp_checker #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_stb,
  input logic                    adl_we,
  input logic                    adl,
  input logic                    prefix_active,
  input logic                    long_data,
  input logic                    long_imm,
  input logic                    int_block,
  input logic                    order_error,
  input logic [ADDR_W-LOW_W-1:0] mbase,
  input logic [ADDR_W-1:0]       hl,
  input logic [ADDR_W-1:0]       ea,
  input logic                    ev_mode_pref,
  input logic                    ev_esc,
  input logic                    ev_final,
  input logic                    ev_misplaced
);
  p_mode_pref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && ev_mode_pref |=> prefix_active && int_block);

  p_default_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prefix_active |-> (long_data == long_imm));

  p_adl_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && ev_mode_pref && !adl_we |=> $stable(adl));

  p_esc_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && ev_esc |=> int_block && !order_error);

  p_final_unblocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && ev_final |=> !int_block);

  p_misplaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && ev_misplaced |=> order_error && !int_block
      && $stable({prefix_active, long_data, long_imm}));

  p_ea_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    long_data |-> ea == hl);

  p_ea_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !long_data |-> ea[ADDR_W-1:LOW_W] == mbase);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |=> $stable({prefix_active, long_data, long_imm, int_block, order_error}));
endmodule

bind mmode_prefix_dec mmp_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .adl_we(adl_we), .adl(adl),
  .prefix_active(prefix_active), .long_data(long_data), .long_imm(long_imm),
  .int_block(int_block), .order_error(order_error), .mbase(mbase), .hl(hl),
  .ea(ea), .ev_mode_pref(ev_mode_pref), .ev_esc(ev_esc), .ev_final(ev_final),
  .ev_misplaced(ev_misplaced)
);

// File: tb/sim_mmode_prefix_dec.sv
`timescale 1ns/1ps
module sim_mmode_prefix_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_stb = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        adl_we = 1'b0;
  logic        adl_d = 1'b0;
  logic [7:0]  mbase = 8'h00;
  logic [23:0] hl = 24'h0;
  logic        adl, prefix_active, long_data, long_imm, int_block, order_error;
  logic [23:0] ea;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmode_prefix_dec u0 (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .opcode(opcode),
    .adl_we(adl_we), .adl_d(adl_d), .mbase(mbase), .hl(hl), .adl(adl),
    .prefix_active(prefix_active), .long_data(long_data), .long_imm(long_imm),
    .int_block(int_block), .order_error(order_error), .ea(ea)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk);
    opcode = b;
    fetch_stb = 1'b1;
    @(negedge clk);
    fetch_stb = 1'b0;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    adl_we = 1'b1;
    adl_d = v;
    @(negedge clk);
    adl_we = 1'b0;
  endtask

  task automatic flags(input string tag, input logic pa, input logic ld,
                       input logic li, input logic ib, input logic oe);
    chk({tag, " prefix_active"}, prefix_active, pa);
    chk({tag, " long_data"}, long_data, ld);
    chk({tag, " long_imm"}, long_imm, li);
    chk({tag, " int_block"}, int_block, ib);
    chk({tag, " order_error"}, order_error, oe);
  endtask

  function automatic logic [7:0] mode_code(input int k);
    return 8'h40 + 8'(9 * k);
  endfunction

  function automatic logic [7:0] esc_byte(input int i);
    case (i)
      0: return 8'hCB;
      1: return 8'hDD;
      2: return 8'hED;
      default: return 8'hFD;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 adl", adl, 0);
    flags("R1", 0, 0, 0, 0, 0);

    // Sweep: mode bit x prefix choice x escape pattern
    for (int a = 0; a < 2; a++) begin
      set_mode(a[0]);
      fetch(8'h00);
      for (int p = 0; p < 5; p++) begin
        for (int e = 0; e < 6; e++) begin
          logic ld, li;
          ld = (p == 0) ? a[0] : 1'((p - 1) & 1);
          li = (p == 0) ? a[0] : 1'(((p - 1) >> 1) & 1);
          if (p != 0) begin
            fetch(mode_code(p - 1));
            flags("R2 prefix", 1, ld, li, 1, 0);
            chk("R4 adl untouched", adl, a);
          end
          if (e == 5) begin
            fetch(8'hDD);
            flags("R6 DD before CB", p != 0, ld, li, 1, 0);
            fetch(8'hCB);
            flags("R6 CB after DD", p != 0, ld, li, 1, 0);
            fetch(8'hCB);
            flags("R6 CB closes", p != 0, ld, li, 0, 0);
          end else if (e > 0) begin
            fetch(esc_byte(e - 1));
            flags("R5 escape blocks", p != 0, ld, li, 1, 0);
            fetch((e == 1 || e == 3) ? 8'hDD : 8'h3E);
            flags("R6 final after escape", p != 0, ld, li, 0, 0);
          end else begin
            fetch(8'h3E);
            flags(p == 0 ? "R3 plain" : "R4 held to final", p != 0, ld, li, 0, 0);
          end
          fetch(8'h00);
          flags("R4 cleared at next insn", 0, a[0], a[0], 0, 0);
        end
      end
    end

    // Misplaced memory-mode codes
    for (int a = 0; a < 2; a++) begin
      set_mode(a[0]);
      fetch(8'h00);
      for (int i = 0; i < 4; i++) begin
        for (int k = 0; k < 4; k++) begin
          fetch(esc_byte(i));
          fetch(mode_code(k));
          flags("R7 misplaced", 0, a[0], a[0], 0, 1);
          fetch(8'h00);
          flags("R7 clears", 0, a[0], a[0], 0, 0);
        end
      end
    end
    set_mode(1'b0);
    fetch(8'h00);
    fetch(8'h5B);
    fetch(8'hFD);
    fetch(8'h40);
    flags("R7 after valid prefix", 1, 1, 1, 0, 1);
    fetch(8'h00);
    flags("R7 next insn", 0, 0, 0, 0, 0);

    // Mode bit written mid-instruction
    fetch(8'hDD);
    flags("R9 before write", 0, 0, 0, 1, 0);
    set_mode(1'b1);
    chk("R9 adl visible", adl, 1);
    fetch(8'h21);
    flags("R9 current insn unchanged", 0, 0, 0, 0, 0);
    fetch(8'h00);
    flags("R9 next insn", 0, 1, 1, 0, 0);

    // No strobe: outputs hold
    fetch(8'hDD);
    set_mode(1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opcode = 8'h40 + 8'(i * 9);
    end
    @(negedge clk);
    flags("R10 hold", 0, 1, 1, 1, 0);
    fetch(8'h00);
    fetch(8'h00);

    // Effective address
    for (int m = 0; m < 2; m++) begin
      fetch(m == 1 ? 8'h49 : 8'h40);
      chk("R8 mode select", long_data, m);
      for (int i = 0; i < 8; i++) begin
        logic [23:0] exp_ea;
        @(negedge clk);
        hl = 24'(i * 32'h2A5F13 + 32'h0107);
        mbase = 8'(i * 37 + 5);
        #1;
        exp_ea = (m == 1) ? hl : (32'(mbase) * 32'h10000 + 32'(hl % 24'h10000));
        chk("R8 ea", ea, exp_ea);
      end
      fetch(8'h00);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule